// File: doc/BRIEF.md
# Sequential 64-bit Integer Multiplier with Overflow Detection

This block is an integer multiply execution unit. A request carries two 64-bit operands and a 7-bit function code. A single shift-and-add datapath forms the unsigned 128-bit product of the two (possibly sign-extended) operands, retiring a few multiplier bits per clock. A small finishing stage then selects the 64-bit result for the requested variant and, for the trapping variants, raises an overflow flag beside it.

The surrounding pipeline pulses `start` with the operands and code. It then waits for the one-cycle `done` pulse, which comes a fixed number of cycles later. The result and flags stay on the outputs until the next `done`. The unit does not deliver traps; it only reports overflow and illegal codes as flags.

Top module: `imul_unit`

## Requirements
- R1: While `rst_n` is low at a clock edge, `done`, `ovf`, `illegal` and `result` are cleared to zero.
- R2: A `start` that is high at an edge is accepted only when no operation is in progress. A `start` seen while an operation is in flight is ignored: it produces no `done` and does not change the result of the running operation. The unit becomes idle again on the edge one cycle after the last multiply step, and a `start` at that edge is accepted.
- R3: `done` is high for exactly one cycle, beginning W/STEP+1 clock edges after the edge that accepted `start` (33 edges with the defaults).
- R4: Code 0x00 multiplies bits 31:0 of both operands as signed numbers and returns the low 32 bits of the product sign-extended to 64 bits. Operand bits 63:32 have no effect.
- R5: Code 0x20 returns bits 63:0 of the product of the two 64-bit operands.
- R6: Code 0x30 returns bits 127:64 of the unsigned 128-bit product.
- R7: Code 0x40 returns the same result as code 0x00. It raises `ovf` unless bits 63:31 of the exact signed 64-bit product are all ones or all zeros.
- R8: Code 0x60 always returns bits 63:0 of the product. It raises `ovf` unless bits 127:64 of the signed 128-bit product equal 64 copies of product bit 63.
- R9: `ovf` is low whenever `done` reports a code other than 0x40 or 0x60.
- R10: Any code other than 0x00, 0x20, 0x30, 0x40 and 0x60 returns a zero result with `illegal` high. `illegal` is low for the five listed codes.
- R11: Between two `done` pulses, `result`, `ovf` and `illegal` hold their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| start | input | 1 | Request pulse, sampled with operands and code |
| func | input | 7 | Function code selecting the multiply variant |
| opa | input | 64 | First operand |
| opb | input | 64 | Second operand |
| done | output | 1 | One-cycle completion pulse |
| result | output | 64 | Selected 64-bit result |
| ovf | output | 1 | Overflow flag of a trapping variant |
| illegal | output | 1 | Unlisted function code was requested |

## Verification
The hardest situation to reach is the `start` that arrives on exactly the edge where the unit turns idle, while the previous `done` has not yet been driven. The bench reaches it by holding `start` high for several operation lengths while the operands change every cycle. The reference model has to pick out each accepted request on its own. The signed-overflow borders are the other hard point. Each 0x40 and 0x60 operand pair is chosen to land one step on either side of the limit: results of exactly +2^31, -2^31, +2^63 and -2^63, and also the minimum value times -1.

// File: rtl/imul_pkg.sv
// Package imul_pkg
// Shared operation kinds and the code-to-kind decoder of the multiply unit.
// Assumes 7-bit function codes; every code not listed decodes to OP_BAD.
package imul_pkg;

    typedef enum logic [2:0] {
        OP_MULL  = 3'd0,   // 32-bit signed, sign-extended result
        OP_MULQ  = 3'd1,   // low 64 bits
        OP_UMULH = 3'd2,   // unsigned high 64 bits
        OP_MULLV = 3'd3,   // 32-bit signed with overflow flag
        OP_MULQV = 3'd4,   // 64-bit with signed overflow flag
        OP_BAD   = 3'd5    // unlisted code
    } mop_e;

    // Map a function code to an operation kind.
    function automatic mop_e decode_code(input logic [6:0] code);
        mop_e k;
        unique case (code)
            7'h00:   k = OP_MULL;
            7'h20:   k = OP_MULQ;
            7'h30:   k = OP_UMULH;
            7'h40:   k = OP_MULLV;
            7'h60:   k = OP_MULQV;
            default: k = OP_BAD;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/imul_decode.sv
// Module imul_decode
// Combinational front end: decodes the function code and prepares the two
// operands for the unsigned core. The 32-bit variants sign-extend the low
// half of each operand, so the low W bits of the unsigned product equal the
// exact signed product. Assumes W is even.
module imul_decode
    import imul_pkg::*;
#(
    parameter int W = 64
) (
    input  logic [6:0]   code,
    input  logic [W-1:0] a_in,
    input  logic [W-1:0] b_in,
    output mop_e         kind,
    output logic [W-1:0] a_x,
    output logic [W-1:0] b_x
);
    localparam int HALF = W / 2;

    // Decode and conditionally sign-extend the operand low halves.
    always_comb begin
        kind = decode_code(code);
        if (kind == OP_MULL || kind == OP_MULLV) begin
            a_x = {{HALF{a_in[HALF-1]}}, a_in[HALF-1:0]};
            b_x = {{HALF{b_in[HALF-1]}}, b_in[HALF-1:0]};
        end else begin
            a_x = a_in;
            b_x = b_in;
        end
    end

endmodule

// File: rtl/imul_core.sv
// Module imul_core
// Sequential unsigned W x W multiplier. It retires STEP multiplier bits per
// clock and needs W/STEP steps. The product register holds the running high
// sum over the not yet consumed multiplier bits. A load is accepted only when
// idle. fin pulses on the cycle after the last step, with prod final.
// Assumes W is a multiple of STEP.
module imul_core #(
    parameter int W    = 64,
    parameter int STEP = 2
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           load,
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic           busy,
    output logic           fin,
    output logic [2*W-1:0] prod
);
    localparam int CYCLES = W / STEP;
    localparam int CNTW   = $clog2(CYCLES) + 1;
    localparam int SW     = W + STEP;

    logic [W-1:0]    mcand;
    logic [CNTW-1:0] cnt;
    logic [SW-1:0]   part;
    logic [SW-1:0]   sum;
    logic [2*W-1:0]  nxt;

    // One step: add digit times multiplicand to the high half, shift right.
    always_comb begin
        part = {{STEP{1'b0}}, mcand} * {{W{1'b0}}, prod[STEP-1:0]};
        sum  = {{STEP{1'b0}}, prod[2*W-1:W]} + part;
        nxt  = {sum, prod[W-1:STEP]};
    end

    // Load on an idle request, iterate while busy, flag completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy  <= 1'b0;
            fin   <= 1'b0;
            cnt   <= '0;
            mcand <= '0;
            prod  <= '0;
        end else begin
            fin <= 1'b0;
            if (load && !busy) begin
                busy  <= 1'b1;
                cnt   <= '0;
                mcand <= a;
                prod  <= {{W{1'b0}}, b};
            end else if (busy) begin
                prod <= nxt;
                cnt  <= cnt + 1'b1;
                if (cnt == CNTW'(CYCLES - 1)) begin
                    busy <= 1'b0;
                    fin  <= 1'b1;
                end
            end
        end
    end

    // R3
    fin_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
        fin |-> ($past(busy) && !busy));

    // R2
    mcand_stable_busy: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> $stable(mcand));

endmodule

// File: rtl/imul_finish.sv
// Module imul_finish
// Combinational back end: forms the signed high half from the unsigned
// product by subtracting each operand where the other one is negative. It
// then selects the result per variant and evaluates the overflow rules.
// Assumes a_q and b_q are the operands the core multiplied.
module imul_finish
    import imul_pkg::*;
#(
    parameter int W = 64
) (
    input  mop_e           kind,
    input  logic [2*W-1:0] prod,
    input  logic [W-1:0]   a_q,
    input  logic [W-1:0]   b_q,
    output logic [W-1:0]   res,
    output logic           ovf,
    output logic           ill
);
    localparam int HALF = W / 2;

    logic [W-1:0]    lo;
    logic [W-1:0]    uhi;
    logic [W-1:0]    shi;
    logic [W-1:0]    lsext;
    logic [HALF:0]   top32;

    // Split the product and derive signed-high and sign-extended views.
    always_comb begin
        lo    = prod[W-1:0];
        uhi   = prod[2*W-1:W];
        shi   = uhi - (a_q[W-1] ? b_q : '0) - (b_q[W-1] ? a_q : '0);
        lsext = {{HALF{lo[HALF-1]}}, lo[HALF-1:0]};
        top32 = lo[W-1:HALF-1];
    end

    // Select result and flags for the requested variant.
    always_comb begin
        res = '0;
        ovf = 1'b0;
        ill = 1'b0;
        unique case (kind)
            OP_MULL:  res = lsext;
            OP_MULQ:  res = lo;
            OP_UMULH: res = uhi;
            OP_MULLV: begin
                res = lsext;
                ovf = !((&top32) || !(|top32));
            end
            OP_MULQV: begin
                res = lo;
                ovf = (shi != {W{lo[W-1]}});
            end
            default:  ill = 1'b1;
        endcase
    end

endmodule

// File: rtl/imul_unit.sv
// Module imul_unit
// Top of the integer multiply unit. It latches the decoded request when the
// core is idle and runs the core, then registers result and flags with a
// one-cycle done pulse. Assumes the caller waits for done before counting on
// a new start being taken; starts during a running operation are dropped.
module imul_unit
    import imul_pkg::*;
#(
    parameter int W    = 64,
    parameter int STEP = 2
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [6:0]   func,
    input  logic [W-1:0] opa,
    input  logic [W-1:0] opb,
    output logic         done,
    output logic [W-1:0] result,
    output logic         ovf,
    output logic         illegal
);
    localparam int HALF = W / 2;

    mop_e           dec_kind;
    mop_e           kind_q;
    logic [W-1:0]   a_x, b_x, a_q, b_q;
    logic           core_busy, core_fin;
    logic [2*W-1:0] core_prod;
    logic [W-1:0]   f_res;
    logic           f_ovf, f_ill;

    imul_decode #(.W(W)) u_dec (
        .code (func),
        .a_in (opa),
        .b_in (opb),
        .kind (dec_kind),
        .a_x  (a_x),
        .b_x  (b_x)
    );

    imul_core #(.W(W), .STEP(STEP)) u_core (
        .clk   (clk),
        .rst_n (rst_n),
        .load  (start),
        .a     (a_x),
        .b     (b_x),
        .busy  (core_busy),
        .fin   (core_fin),
        .prod  (core_prod)
    );

    imul_finish #(.W(W)) u_fin (
        .kind (kind_q),
        .prod (core_prod),
        .a_q  (a_q),
        .b_q  (b_q),
        .res  (f_res),
        .ovf  (f_ovf),
        .ill  (f_ill)
    );

    // Capture the request on acceptance and register the outcome on finish.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            kind_q  <= OP_MULL;
            a_q     <= '0;
            b_q     <= '0;
            done    <= 1'b0;
            result  <= '0;
            ovf     <= 1'b0;
            illegal <= 1'b0;
        end else begin
            if (start && !core_busy) begin
                kind_q <= dec_kind;
                a_q    <= a_x;
                b_q    <= b_x;
            end
            done <= core_fin;
            if (core_fin) begin
                result  <= f_res;
                ovf     <= f_ovf;
                illegal <= f_ill;
            end
        end
    end

    // R3
    done_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R2
    request_held_busy: assert property (@(posedge clk) disable iff (!rst_n)
        core_busy |=> $stable(kind_q));

    // R9
    ovf_trap_only: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(kind_q) != OP_MULLV && $past(kind_q) != OP_MULQV) |-> !ovf);

    // R10
    illegal_zero_res: assert property (@(posedge clk) disable iff (!rst_n)
        (done && illegal) |-> (result == '0));

    // R4
    mull_sign_ext: assert property (@(posedge clk) disable iff (!rst_n)
        (done && $past(kind_q) == OP_MULL) |-> (result[W-1:HALF] == {HALF{result[HALF-1]}}));

    // R11
    outputs_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> ($stable(result) && $stable(ovf) && $stable(illegal)));

endmodule

// File: tb/imul_unit_test.sv
`timescale 1ns/1ps
module imul_unit_test;

    localparam int W    = 64;
    localparam int STEP = 2;
    localparam int LAT  = W / STEP + 1;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [6:0]  func = '0;
    logic [63:0] opa = '0, opb = '0;
    logic        done, ovf, illegal;
    logic [63:0] result;

    int compared = 0;
    int mismatched = 0;
    int cyc = 0;
    int last_acc = -100000;
    bit finished = 0;

    typedef struct {
        int          due;
        logic [6:0]  f;
        logic [63:0] r;
        logic        o;
        logic        il;
    } exp_t;
    exp_t q[$];

    logic [63:0] hold_r = '0;
    logic        hold_o = 1'b0, hold_il = 1'b0;

    always #10 clk = ~clk;   // 50 MHz

    imul_unit #(.W(W), .STEP(STEP)) uut (
        .clk(clk), .rst_n(rst_n), .start(start), .func(func),
        .opa(opa), .opb(opb), .done(done), .result(result),
        .ovf(ovf), .illegal(illegal)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [63:0] act, input logic [63:0] exp);
        compared++;
        if (!ok) begin
            mismatched++;
            $display("FAIL %s %s: actual %h expected %h (cycle %0d)", req, what, act, exp, cyc);
        end
    endtask

    // Behavioural reference from the requirement text.
    function automatic void model(input logic [6:0] f, input logic [63:0] a, input logic [63:0] b,
                                  output logic [63:0] r, output logic o, output logic il);
        longint        p32;
        logic [127:0]  u;
        logic signed [127:0] s;
        r = '0; o = 1'b0; il = 1'b0;
        case (f)
            7'h00, 7'h40: begin
                p32 = longint'($signed(a[31:0])) * longint'($signed(b[31:0]));
                r = {{32{p32[31]}}, p32[31:0]};
                if (f == 7'h40) o = !(p32[63:31] == 33'd0 || p32[63:31] == {33{1'b1}});
            end
            7'h20: r = a * b;
            7'h30: begin
                u = {64'd0, a} * {64'd0, b};
                r = u[127:64];
            end
            7'h60: begin
                s = $signed({{64{a[63]}}, a}) * $signed({{64{b[63]}}, b});
                r = s[63:0];
                o = (s[127:64] != {64{s[63]}});
            end
            default: il = 1'b1;
        endcase
    endfunction

    function automatic string tag(input logic [6:0] f);
        case (f)
            7'h00: return "R4";
            7'h20: return "R5";
            7'h30: return "R6";
            7'h40: return "R7";
            7'h60: return "R8";
            default: return "R10";
        endcase
    endfunction

    // Per-cycle comparison against the model, sampled at the falling edge.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            cyc++;
            if (q.size() > 0 && q[0].due == cyc) begin
                check(done == 1'b1, "R3", "done pulse", 64'(done), 64'd1);
                check(result == q[0].r, tag(q[0].f), "result", result, q[0].r);
                check(ovf == q[0].o,
                      (q[0].f == 7'h40 || q[0].f == 7'h60) ? tag(q[0].f) : "R9",
                      "ovf", 64'(ovf), 64'(q[0].o));
                check(illegal == q[0].il, "R10", "illegal", 64'(illegal), 64'(q[0].il));
                hold_r = result; hold_o = ovf; hold_il = illegal;
                void'(q.pop_front());
            end else begin
                check(done == 1'b0, "R2", "no done expected", 64'(done), 64'd0);
                check(result == hold_r && ovf == hold_o && illegal == hold_il,
                      "R11", "outputs held", result, hold_r);
            end
            // Acceptance decision for the coming rising edge.
            if (start && (cyc + 1 - last_acc >= LAT)) begin
                exp_t e;
                e.due = cyc + 1 + LAT;
                e.f = func;
                model(func, opa, opb, e.r, e.o, e.il);
                q.push_back(e);
                last_acc = cyc + 1;
            end
        end
    end

    task automatic issue(input logic [6:0] f, input logic [63:0] a, input logic [63:0] b);
        @(posedge clk); #2;
        start = 1'b1; func = f; opa = a; opb = b;
        @(posedge clk); #2;
        start = 1'b0;
        repeat (LAT + 1) @(posedge clk);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
            $finish;
        end
    endtask

    initial begin
        #(20 * 200000);
        mismatched++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #2;
        // R1: reset state after edges with rst_n low
        check(done == 0 && ovf == 0 && illegal == 0 && result == 0, "R1", "reset state",
              result, 64'd0);
        rst_n = 1'b1;

        // R4: low-half signed multiply, upper bits ignored
        issue(7'h00, 64'hDEAD_BEEF_0000_0007, 64'h1234_5678_FFFF_FFFD);
        issue(7'h00, 64'h0000_0000_0001_0000, 64'h0000_0000_0000_8000);
        // R5
        issue(7'h20, 64'hFFFF_FFFF_FFFF_FFFF, 64'h0000_0000_0000_0003);
        issue(7'h20, 64'h0123_4567_89AB_CDEF, 64'hFEDC_BA98_7654_3210);
        // R6
        issue(7'h30, 64'hFFFF_FFFF_FFFF_FFFF, 64'hFFFF_FFFF_FFFF_FFFF);
        issue(7'h30, 64'h8000_0000_0000_0000, 64'h0000_0000_0000_0002);
        // R7: borders of the 32-bit signed range
        issue(7'h40, 64'h0000_0000_7FFF_FFFF, 64'h0000_0000_0000_0001);
        issue(7'h40, 64'h0000_0000_0001_0000, 64'h0000_0000_0000_8000);
        issue(7'h40, 64'hFFFF_FFFF_FFFF_8000, 64'h0000_0000_0001_0000);
        issue(7'h40, 64'h0000_0000_8000_0000, 64'h0000_0000_FFFF_FFFF);
        // R8: borders of the 64-bit signed range
        issue(7'h60, 64'h8000_0000_0000_0000, 64'h0000_0000_0000_0001);
        issue(7'h60, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF);
        issue(7'h60, 64'h0000_0001_0000_0000, 64'h0000_0000_8000_0000);
        issue(7'h60, 64'hFFFF_FFFF_0000_0000, 64'h0000_0000_8000_0000);
        issue(7'h60, 64'hFFFF_FFFF_FFFF_FFFD, 64'h0000_0000_0000_0007);
        // R10: unlisted codes
        issue(7'h10, 64'h5, 64'h6);
        issue(7'h7F, 64'hFFFF, 64'hFFFF);
        // R9: non-trapping code with large product keeps ovf low
        issue(7'h20, 64'h8000_0000_0000_0000, 64'hFFFF_FFFF_FFFF_FFFF);

        // R2: a second start while busy is ignored
        @(posedge clk); #2;
        start = 1'b1; func = 7'h20; opa = 64'd9; opb = 64'd11;
        @(posedge clk); #2;
        start = 1'b0;
        repeat (4) @(posedge clk); #2;
        start = 1'b1; func = 7'h30; opa = '1; opb = '1;
        @(posedge clk); #2;
        start = 1'b0;
        repeat (LAT + 2) @(posedge clk);

        // R2/R3: start held high, operands change every cycle
        for (int i = 0; i < 3 * LAT + 5; i++) begin
            @(posedge clk); #2;
            start = 1'b1;
            case (i % 5)
                0: func = 7'h00;
                1: func = 7'h20;
                2: func = 7'h30;
                3: func = 7'h40;
                default: func = 7'h60;
            endcase
            opa = {$urandom, $urandom};
            opb = {$urandom, $urandom};
        end
        @(posedge clk); #2;
        start = 1'b0;
        repeat (LAT + 2) @(posedge clk);

        // Random mix of codes and operands
        for (int i = 0; i < 60; i++) begin
            logic [6:0] f;
            case ($urandom % 6)
                0: f = 7'h00;
                1: f = 7'h20;
                2: f = 7'h30;
                3: f = 7'h40;
                4: f = 7'h60;
                default: f = 7'($urandom);
            endcase
            if (i % 3 == 0)
                issue(f, {{32{1'b0}}, $urandom}, {{32{1'b1}}, $urandom});
            else
                issue(f, {$urandom, $urandom}, {$urandom, $urandom});
        end

        repeat (4) @(posedge clk);
        check(q.size() == 0, "R3", "all requests completed", 64'(q.size()), 64'd0);
        finish_run();
    end

endmodule